// File: doc/BRIEF.md
# Multi-Precision Partial-Product MAC Combiner

This block is the digital back end of a bit-sliced compute-in-memory array. The analog array and its converter deliver, for each word-line row, up to four 8-bit partial-product codes. Each code is the product of one slice of the input with one slice of the stored weight. In a single cycle the block shift-adds those codes into one unsigned row product. It adds the row products of all rows into one of two accumulators, chosen by the polarity tag that comes with the row. It then subtracts the negative-layer total from the positive-layer total, which gives a signed dot product. Because of that subtraction the weight carries one extra bit of precision.

A precision mode is sampled when a run starts and held until the run ends. Mode 0 is 1-bit input with 2-bit weight. Mode 1 is 4-bit input with 5-bit weight. Mode 2 is 8-bit input with 9-bit weight. Mode 3 is reserved and behaves like mode 0. A typical run has one `start_i` pulse, then 32 valid positive rows, then 32 valid negative rows. The block then raises `done_o` for one cycle and presents the result on `res_o`. A `clear_i` pulse zeroes both totals and both row counts in the middle of a run without ending it.

Top module: `pp_mac_combiner`

## Requirements
- R1: After synchronous reset, `done_o` is 0 and `res_o` is 0.
- R2: In mode 2 the row product is slot3·256 + (slot2 + slot1)·16 + slot0. Slot k is `pc_codes_i[8k+7:8k]`, and slots 0 to 3 carry the low×low, low×high, high×low and high×high nibble products.
- R3: In mode 1 the row product is slot0 + slot1·4, and slots 2 and 3 have no effect.
- R4: In mode 0, and in the reserved mode 3, the row product is slot0 alone, and slots 1 to 3 have no effect.
- R5: `res_o` is a 23-bit two's-complement value equal to the sum of the positive-row products minus the sum of the negative-row products. A row is positive when `pc_neg_i`=0 and negative when `pc_neg_i`=1.
- R6: When the edge that absorbs the 32nd negative row has passed, `done_o` is still 0. `done_o` is 1 for exactly one cycle after the following edge, with `res_o` valid at that point. `res_o` then holds its value until the next completed run.
- R7: Rows are ignored when `pc_valid_i` is 0, when no run is active, or when their polarity has already absorbed 32 rows in the current run. Rows that arrive in the same cycle as `start_i` or `clear_i` are also ignored.
- R8: The mode is sampled on `start_i`; changes to `mode_i` during a run have no effect.
- R9: `clear_i` zeroes both totals and both row counts. The run stays active.
- R10: Totals never wrap. Full-scale operands (all slots 0xFF, 32 rows, mode 2) give +2358240 or −2358240.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Precision mode, sampled on start |
| start_i | input | 1 | Begin a run: latch mode, zero totals and counts |
| clear_i | input | 1 | Zero totals and counts within a run |
| pc_valid_i | input | 1 | Row of partial codes is present |
| pc_neg_i | input | 1 | Row belongs to the negative-weight layer |
| pc_codes_i | input | 32 | Four 8-bit partial codes, slot k at bits 8k+7:8k |
| res_o | output | 23 | Signed dot-product result |
| done_o | output | 1 | One-cycle result-ready pulse |

## Verification
A row driven before a clock edge enters its total at that edge. The subtraction and `done_o` follow one edge later, so the result is due two edges after the final negative row is driven. The bench drives inputs on falling edges and samples outputs on the falling edges in between. It checks that `done_o` is still low half a cycle after the absorbing edge, high one cycle later, and low again on the cycle after that, while `res_o` holds. The checks for ignored input look at `res_o` and `done_o` on the completed run that follows, or on the held result.

// File: rtl/ppmac_pkg.sv
package ppmac_pkg;
  // Precision modes; any other code is handled like PM_1B
  typedef enum logic [1:0] {
    PM_1B = 2'd0,
    PM_4B = 2'd1,
    PM_8B = 2'd2,
    PM_RSV = 2'd3
  } prec_mode_e;
endpackage

// File: rtl/ppmac_combine.sv
module ppmac_combine
  import ppmac_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int IN_W   = 8,
  parameter int SLOTS  = 4,
  parameter int PROD_W = CODE_W + IN_W + 1
) (
  input  prec_mode_e                 mode,
  input  logic [SLOTS*CODE_W-1:0]    codes,
  output logic [PROD_W-1:0]          prod
);
  localparam int SH_HI  = IN_W;      // high x high slice weight
  localparam int SH_MID = IN_W / 2;  // cross nibble slices
  localparam int SH_4B  = IN_W / 4;  // high half of a 4-bit input

  logic [PROD_W-1:0] s [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign s[g] = PROD_W'(codes[g*CODE_W +: CODE_W]);
  end

  always_comb begin
    case (mode)
      PM_8B:   prod = (s[3] << SH_HI) + (s[2] << SH_MID) + (s[1] << SH_MID) + s[0];
      PM_4B:   prod = s[0] + (s[1] << SH_4B);
      default: prod = s[0];
    endcase
  end
endmodule

// File: rtl/ppmac_accum.sv
module ppmac_accum #(
  parameter int ROWS   = 32,
  parameter int PROD_W = 17,
  parameter int ACC_W  = PROD_W + $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zero_i,
  input  logic              take_i,
  input  logic [PROD_W-1:0] prod_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              last_o
);
  localparam int CNT_W = $clog2(ROWS + 1);

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;
  logic             absorb;

  assign full   = (cnt_q == CNT_W'(ROWS));
  assign absorb = take_i & ~full;
  assign last_o = absorb & (cnt_q == CNT_W'(ROWS - 1));
  assign acc_o  = acc_q;

  always_ff @(posedge clk) begin
    if (rst || zero_i) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (absorb) begin
      acc_q <= acc_q + ACC_W'(prod_i);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10
  acc_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
    !zero_i |=> acc_q >= $past(acc_q));

  // R7
  row_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(ROWS));
endmodule

// File: rtl/pp_mac_combiner.sv
module pp_mac_combiner
  import ppmac_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int IN_W   = 8,
  parameter int ROWS   = 32
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [1:0]                                mode_i,
  input  logic                                      start_i,
  input  logic                                      clear_i,
  input  logic                                      pc_valid_i,
  input  logic                                      pc_neg_i,
  input  logic [4*CODE_W-1:0]                       pc_codes_i,
  output logic [CODE_W+IN_W+1+$clog2(ROWS):0]       res_o,
  output logic                                      done_o
);
  localparam int SLOTS  = 4;
  localparam int PROD_W = CODE_W + IN_W + 1;
  localparam int ACC_W  = PROD_W + $clog2(ROWS);
  localparam int RES_W  = ACC_W + 1;

  prec_mode_e         mode_q;
  logic               busy_q;
  logic               fin_q;
  logic               done_q;
  logic [RES_W-1:0]   res_q;
  logic               zero;
  logic               row_ok;
  logic [PROD_W-1:0]  prod;
  logic [ACC_W-1:0]   acc  [2];
  logic               last [2];

  assign zero   = start_i | clear_i;
  assign row_ok = busy_q & pc_valid_i & ~zero;

  ppmac_combine #(
    .CODE_W (CODE_W),
    .IN_W   (IN_W),
    .SLOTS  (SLOTS),
    .PROD_W (PROD_W)
  ) u_comb (
    .mode  (mode_q),
    .codes (pc_codes_i),
    .prod  (prod)
  );

  // Index 0: positive-weight layer, index 1: negative-weight layer
  for (genvar p = 0; p < 2; p++) begin : g_pol
    ppmac_accum #(
      .ROWS   (ROWS),
      .PROD_W (PROD_W),
      .ACC_W  (ACC_W)
    ) u_acc (
      .clk    (clk),
      .rst    (rst),
      .zero_i (zero),
      .take_i (row_ok & (pc_neg_i == 1'(p))),
      .prod_i (prod),
      .acc_o  (acc[p]),
      .last_o (last[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PM_1B;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      fin_q  <= last[1];
      if (fin_q) begin
        res_q  <= {1'b0, acc[0]} - {1'b0, acc[1]};
        done_q <= 1'b1;
        busy_q <= 1'b0;
      end
      if (clear_i) fin_q <= 1'b0;
      if (start_i) begin
        mode_q <= prec_mode_e'(mode_i);
        busy_q <= 1'b1;
        fin_q  <= 1'b0;
      end
    end
  end

  assign res_o  = res_q;
  assign done_o = done_q;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(last[1], 2));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !start_i) |=> $stable(mode_q));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !start_i && !clear_i) |=> ($stable(acc[0]) && $stable(acc[1])));

  // R4
  one_bit_range_chk: assert property (@(posedge clk) disable iff (rst)
    (row_ok && (mode_q == PM_1B)) |-> (prod < PROD_W'(1 << CODE_W)));
endmodule

// File: tb/pp_mac_combiner_tb.sv
module pp_mac_combiner_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_i = 2'd0;
  logic        start_i = 1'b0;
  logic        clear_i = 1'b0;
  logic        pc_valid_i = 1'b0;
  logic        pc_neg_i = 1'b0;
  logic [31:0] pc_codes_i = '0;
  logic [22:0] res_o;
  logic        done_o;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pp_mac_combiner dut_i (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .start_i    (start_i),
    .clear_i    (clear_i),
    .pc_valid_i (pc_valid_i),
    .pc_neg_i   (pc_neg_i),
    .pc_codes_i (pc_codes_i),
    .res_o      (res_o),
    .done_o     (done_o)
  );

  typedef struct packed {
    logic [1:0]  m;
    logic [31:0] p;
    logic [31:0] n;
    int          e;
  } vec_t;

  // mode, positive row codes, negative row codes, expected result (32 rows each)
  localparam vec_t VECS [7] = '{
    '{2'd2, 32'h01020304, 32'h00000000, 10880},    // R2
    '{2'd2, 32'h00000000, 32'h00000010, -512},     // R5
    '{2'd1, 32'hFFFF0305, 32'h00000102, 352},      // R3
    '{2'd0, 32'hFFFFFF09, 32'hFFFFFF03, 192},      // R4
    '{2'd2, 32'hFFFFFFFF, 32'h00000000, 2358240},  // R10
    '{2'd2, 32'h00000000, 32'hFFFFFFFF, -2358240}, // R10
    '{2'd2, 32'h80402010, 32'h01000000, 1090048}   // R2
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic start_run(input logic [1:0] m);
    mode_i  = m;
    start_i = 1'b1;
    cyc();
    start_i = 1'b0;
  endtask

  task automatic feed(input bit neg, input logic [31:0] c, input int n);
    for (int i = 0; i < n; i++) begin
      pc_valid_i = 1'b1;
      pc_neg_i   = neg;
      pc_codes_i = c;
      cyc();
    end
    pc_valid_i = 1'b0;
  endtask

  // Called half a cycle after the edge that absorbed the 32nd negative row
  task automatic finish_check(input int exp, input string req);
    int act;
    chk(done_o == 1'b0, {req, " R6 done early"}, int'(done_o), 0);
    cyc();
    act = int'($signed(res_o));
    chk(done_o == 1'b1, {req, " R6 done due"}, int'(done_o), 1);
    chk(act == exp, {req, " R5 result"}, act, exp);
    cyc();
    act = int'($signed(res_o));
    chk(done_o == 1'b0 && act == exp, {req, " R6 pulse/hold"}, act, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=end");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc();
    // R1 reset state
    chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
    chk(res_o == '0, "R1 res", int'($signed(res_o)), 0);

    // Vector table
    foreach (VECS[k]) begin
      start_run(VECS[k].m);
      feed(1'b0, VECS[k].p, 32);
      feed(1'b1, VECS[k].n, 32);
      finish_check(VECS[k].e, $sformatf("vec%0d", k));
    end

    // R7 rows while idle are ignored: result holds, no done
    held = int'($signed(res_o));
    feed(1'b0, 32'hFFFFFFFF, 4);
    feed(1'b1, 32'hFFFFFFFF, 4);
    cyc();
    chk(done_o == 1'b0, "R7 idle no done", int'(done_o), 0);
    chk(int'($signed(res_o)) == held, "R7 idle hold", int'($signed(res_o)), held);

    // R7 invalid rows and surplus rows ignored
    start_run(2'd2);
    pc_codes_i = 32'hFFFFFFFF;
    pc_neg_i   = 1'b0;
    repeat (5) cyc();
    feed(1'b0, 32'h00000001, 32);
    feed(1'b0, 32'hFFFFFFFF, 3);
    feed(1'b1, 32'h00000000, 32);
    finish_check(32, "R7 valid/surplus");

    // R8 mode change during a run has no effect
    start_run(2'd0);
    mode_i = 2'd2;
    feed(1'b0, 32'h01010101, 32);
    feed(1'b1, 32'h00000000, 32);
    finish_check(32, "R8 mode held");

    // R9 clear zeroes totals and counts mid-run
    start_run(2'd2);
    feed(1'b0, 32'hFFFFFFFF, 10);
    feed(1'b1, 32'h00000001, 5);
    clear_i = 1'b1;
    cyc();
    clear_i = 1'b0;
    feed(1'b0, 32'h00000002, 32);
    feed(1'b1, 32'h00000001, 32);
    finish_check(32, "R9 clear");

    // R4 reserved mode 3 acts as single slot
    start_run(2'd3);
    feed(1'b0, 32'hFFFFFF07, 32);
    feed(1'b1, 32'h00000000, 32);
    finish_check(224, "R4 mode3");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule